// File: doc/BRIEF.md
# Software Write-Protection Command Sequencer

This block sits beside the page-load logic of a byte-wide nonvolatile memory. It watches every write strobe with its 15-bit address and 8-bit data. Within one page-load window it recognises two command patterns: a three-write lock pattern that arms software write protection, and a six-write unlock pattern that removes it. Each write that belongs to a command is flagged one cycle later, so the page buffer can drop that byte. When the load window closes, the block always starts the internal write timer. Alongside that start it says whether the page data may really be committed to the array.

The protection flag is nonvolatile. Reset does not clear it. It changes only when the page-write engine reports the end of the write cycle that carried the command. Once protected, the array can still be written: the host sends the three-write lock pattern as a prefix and then the data bytes, all in one load window. A protected load with no prefix still runs the timer, but its commit permission is withheld.

Top module: `spw_guard`

## Requirements
- R1: A load window closes after LOAD_TIMEOUT (default 8) consecutive clock cycles with no accepted write, counted from the last accepted write. With the default, `timer_start` is high for exactly one cycle, 8 cycles after the edge that sampled the last write. This holds whether or not the block is protected.
- R2: `commit_ok` is high only in the cycle where `timer_start` is high. In that cycle it is 1 when `prot_on` is 0, or when the lock pattern was completed within that load. Otherwise it is 0.
- R3: The lock pattern is data AAh to address 5555h, then 55h to 2AAAh, then A0h to 5555h. Once it completes, `prot_on` becomes 1 on the first `cycle_done` after that load's `timer_start`. It does not change earlier.
- R4: The unlock pattern is AAh/5555h, 55h/2AAAh, 80h/5555h, AAh/5555h, 55h/2AAAh, 20h/5555h. Once it completes, `prot_on` becomes 0 on the first `cycle_done` after that load's `timer_start`.
- R5: `cmd_suppress` is 1 in the cycle after an accepted write that matches the next expected command step. It is 0 after any other write, and 0 in any cycle that follows no write.
- R6: A write that breaks the pattern restarts matching. If that write is itself AAh to 5555h, it counts as step one and is suppressed; otherwise it is a data write.
- R7: After a lock or unlock pattern has completed, every remaining write in the same load is a data write, even if it looks like a command byte.
- R8: When a load window closes, any partial pattern is abandoned. A pattern split across two loads does not complete.
- R9: From `timer_start` until `cycle_done`, writes are ignored: they are not suppressed, they do not start a new load and they do not advance matching. A `cycle_done` seen outside that interval has no effect.
- R10: Synchronous reset clears the outputs `timer_start`, `commit_ok` and `cmd_suppress`, any partial pattern and any open load. It leaves `prot_on` unchanged. At power-up `prot_on` equals PROT_INIT (default 0).
- R11: `prot_on` changes only on a clock edge where `cycle_done` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-cycle pulse per host write |
| wr_addr | input | 15 | Write address |
| wr_data | input | 8 | Write data |
| cycle_done | input | 1 | End of the internal write cycle, from the page-write engine |
| commit_ok | output | 1 | Page may be committed (valid with timer_start) |
| cmd_suppress | output | 1 | The previous write was a command byte |
| prot_on | output | 1 | Software write protection active |
| timer_start | output | 1 | Start the internal write cycle timer |

## Verification
A wrong step register would first show on `cmd_suppress`, one cycle after the write that should or should not have matched. Because of R7, it would also mark later data bytes wrongly within the same load. A wrong load-scope flag stays hidden until the window closes. It then appears on `commit_ok` in the `timer_start` cycle, LOAD_TIMEOUT cycles after the last write. A wrong pending bit reaches `prot_on` only at the next `cycle_done`, and only the commit decision of the following load exposes it. For that reason, each protection change is followed by a plain load and a prefixed load.

// File: rtl/spw_pkg.sv
package spw_pkg;

    localparam int ADDR_W = 15;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] CMD_ADDR_A = 15'h5555;
    localparam logic [ADDR_W-1:0] CMD_ADDR_B = 15'h2AAA;
    localparam logic [DATA_W-1:0] KEY_FIRST  = 8'hAA;
    localparam logic [DATA_W-1:0] KEY_SECOND = 8'h55;
    localparam logic [DATA_W-1:0] OP_LOCK    = 8'hA0;
    localparam logic [DATA_W-1:0] OP_EXTEND  = 8'h80;
    localparam logic [DATA_W-1:0] OP_UNLOCK  = 8'h20;

    // Position inside the command pattern: the next expected step
    typedef enum logic [2:0] {
        ST_KEY1,
        ST_KEY2,
        ST_OPCODE,
        ST_XKEY1,
        ST_XKEY2,
        ST_XOP,
        ST_CLOSED
    } step_e;

    typedef struct packed {
        logic  hit;
        logic  lock_done;
        logic  unlock_done;
        step_e next;
    } match_t;

    function automatic logic is_pair(input logic [ADDR_W-1:0] a,
                                     input logic [DATA_W-1:0] d,
                                     input logic [ADDR_W-1:0] ea,
                                     input logic [DATA_W-1:0] ed);
        return (a == ea) && (d == ed);
    endfunction

    // Evaluate one write against the current step.
    function automatic match_t step_eval(input step_e cur,
                                         input logic [ADDR_W-1:0] a,
                                         input logic [DATA_W-1:0] d);
        match_t m;
        m.hit         = 1'b0;
        m.lock_done   = 1'b0;
        m.unlock_done = 1'b0;
        m.next        = ST_KEY1;
        case (cur)
            ST_KEY1: begin
                if (is_pair(a, d, CMD_ADDR_A, KEY_FIRST)) begin
                    m.hit  = 1'b1;
                    m.next = ST_KEY2;
                end
            end
            ST_KEY2: begin
                if (is_pair(a, d, CMD_ADDR_B, KEY_SECOND)) begin
                    m.hit  = 1'b1;
                    m.next = ST_OPCODE;
                end
            end
            ST_OPCODE: begin
                if (is_pair(a, d, CMD_ADDR_A, OP_LOCK)) begin
                    m.hit       = 1'b1;
                    m.lock_done = 1'b1;
                    m.next      = ST_CLOSED;
                end else if (is_pair(a, d, CMD_ADDR_A, OP_EXTEND)) begin
                    m.hit  = 1'b1;
                    m.next = ST_XKEY1;
                end
            end
            ST_XKEY1: begin
                if (is_pair(a, d, CMD_ADDR_A, KEY_FIRST)) begin
                    m.hit  = 1'b1;
                    m.next = ST_XKEY2;
                end
            end
            ST_XKEY2: begin
                if (is_pair(a, d, CMD_ADDR_B, KEY_SECOND)) begin
                    m.hit  = 1'b1;
                    m.next = ST_XOP;
                end
            end
            ST_XOP: begin
                if (is_pair(a, d, CMD_ADDR_A, OP_UNLOCK)) begin
                    m.hit         = 1'b1;
                    m.unlock_done = 1'b1;
                    m.next        = ST_CLOSED;
                end
            end
            default: begin
                m.next = ST_CLOSED;
            end
        endcase
        // A broken pattern restarts; the breaking write may itself be step one
        if (!m.hit && cur != ST_CLOSED && is_pair(a, d, CMD_ADDR_A, KEY_FIRST)) begin
            m.hit  = 1'b1;
            m.next = ST_KEY2;
        end
        return m;
    endfunction

endpackage

// File: rtl/spw_seq_match.sv
module spw_seq_match
    import spw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_acc,
    input  logic              flush,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              hit,
    output logic              lock_done,
    output logic              unlock_done
);

    step_e  step_q;
    match_t eval;

    always_comb begin
        eval        = step_eval(step_q, addr, data);
        hit         = wr_acc & eval.hit;
        lock_done   = wr_acc & eval.lock_done;
        unlock_done = wr_acc & eval.unlock_done;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            step_q <= ST_KEY1;
        end else if (wr_acc) begin
            step_q <= eval.next;
        end
    end

endmodule

// File: rtl/spw_load_window.sv
module spw_load_window #(
    parameter int LOAD_TIMEOUT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_stb,
    input  logic cycle_done,
    output logic wr_acc,
    output logic close,
    output logic busy
);

    localparam int GAP_W = $clog2(LOAD_TIMEOUT + 1);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(LOAD_TIMEOUT - 1);

    logic             loading_q;
    logic             busy_q;
    logic [GAP_W-1:0] gap_q;

    assign busy   = busy_q;
    assign wr_acc = wr_stb & ~busy_q;
    assign close  = loading_q & ~wr_acc & (gap_q == GAP_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            loading_q <= 1'b0;
            busy_q    <= 1'b0;
            gap_q     <= '0;
        end else begin
            if (wr_acc) begin
                loading_q <= 1'b1;
                gap_q     <= '0;
            end else if (close) begin
                loading_q <= 1'b0;
                busy_q    <= 1'b1;
                gap_q     <= '0;
            end else if (loading_q) begin
                gap_q <= gap_q + 1'b1;
            end
            if (busy_q && cycle_done) begin
                busy_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/spw_prot_flag.sv
module spw_prot_flag #(
    parameter bit PROT_INIT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic set_lock,
    input  logic set_unlock,
    input  logic close,
    input  logic busy,
    input  logic cycle_done,
    output logic lock_seen,
    output logic prot
);

    logic seen_lock_q;
    logic seen_unlock_q;
    logic pend_lock_q;
    logic pend_unlock_q;
    // Nonvolatile: only the power-up value, never reset
    logic prot_q = PROT_INIT;

    assign lock_seen = seen_lock_q;
    assign prot      = prot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_lock_q   <= 1'b0;
            seen_unlock_q <= 1'b0;
            pend_lock_q   <= 1'b0;
            pend_unlock_q <= 1'b0;
        end else begin
            if (close) begin
                pend_lock_q   <= seen_lock_q;
                pend_unlock_q <= seen_unlock_q;
                seen_lock_q   <= 1'b0;
                seen_unlock_q <= 1'b0;
            end else begin
                if (set_lock)   seen_lock_q   <= 1'b1;
                if (set_unlock) seen_unlock_q <= 1'b1;
            end
            if (busy && cycle_done) begin
                pend_lock_q   <= 1'b0;
                pend_unlock_q <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && busy && cycle_done) begin
            if (pend_lock_q) begin
                prot_q <= 1'b1;
            end else if (pend_unlock_q) begin
                prot_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/spw_guard.sv
module spw_guard
    import spw_pkg::*;
#(
    parameter int LOAD_TIMEOUT = 8,
    parameter bit PROT_INIT    = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cycle_done,
    output logic              commit_ok,
    output logic              cmd_suppress,
    output logic              prot_on,
    output logic              timer_start
);

    logic wr_acc;
    logic close;
    logic busy;
    logic hit;
    logic lock_done;
    logic unlock_done;
    logic lock_seen;
    logic prot;

    logic commit_q;
    logic suppress_q;
    logic start_q;

    spw_load_window #(.LOAD_TIMEOUT(LOAD_TIMEOUT)) u_window (
        .clk        (clk),
        .rst        (rst),
        .wr_stb     (wr_stb),
        .cycle_done (cycle_done),
        .wr_acc     (wr_acc),
        .close      (close),
        .busy       (busy)
    );

    spw_seq_match u_match (
        .clk         (clk),
        .rst         (rst),
        .wr_acc      (wr_acc),
        .flush       (close),
        .addr        (wr_addr),
        .data        (wr_data),
        .hit         (hit),
        .lock_done   (lock_done),
        .unlock_done (unlock_done)
    );

    spw_prot_flag #(.PROT_INIT(PROT_INIT)) u_flag (
        .clk        (clk),
        .rst        (rst),
        .set_lock   (lock_done),
        .set_unlock (unlock_done),
        .close      (close),
        .busy       (busy),
        .cycle_done (cycle_done),
        .lock_seen  (lock_seen),
        .prot       (prot)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            commit_q   <= 1'b0;
            suppress_q <= 1'b0;
            start_q    <= 1'b0;
        end else begin
            start_q    <= close;
            commit_q   <= close & (~prot | lock_seen);
            suppress_q <= hit;
        end
    end

    assign commit_ok    = commit_q;
    assign cmd_suppress = suppress_q;
    assign timer_start  = start_q;
    assign prot_on      = prot;

endmodule

// File: rtl/spw_guard_chk.sv
module spw_guard_chk (
    input logic clk,
    input logic rst,
    input logic wr_stb,
    input logic cycle_done,
    input logic commit_ok,
    input logic cmd_suppress,
    input logic prot_on,
    input logic timer_start
);

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        timer_start |=> !timer_start); // R1

    AST_COMMIT_WITH_START: assert property (@(posedge clk) disable iff (rst)
        commit_ok |-> timer_start); // R2

    AST_OPEN_COMMITS: assert property (@(posedge clk) disable iff (rst)
        (timer_start && !prot_on) |-> commit_ok); // R2

    AST_SUPPRESS_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> !cmd_suppress); // R5

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !cycle_done |=> $stable(prot_on)); // R11

endmodule

bind spw_guard spw_guard_chk u_chk (.*);

// File: tb/tb_spw_guard.sv
module tb_spw_guard;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_stb = 1'b0;
    logic [14:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        cycle_done = 1'b0;
    logic        commit_ok;
    logic        cmd_suppress;
    logic        prot_on;
    logic        timer_start;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    spw_guard dut (
        .clk          (clk),
        .rst          (rst),
        .wr_stb       (wr_stb),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .cycle_done   (cycle_done),
        .commit_ok    (commit_ok),
        .cmd_suppress (cmd_suppress),
        .prot_on      (prot_on),
        .timer_start  (timer_start)
    );

    // {addr, data, expected suppress, last write of load, expected commit}
    localparam int NV = 17;
    localparam logic [25:0] VEC [NV] = '{
        {15'h0123, 8'h11, 1'b0, 1'b0, 1'b0},
        {15'h5555, 8'hAA, 1'b1, 1'b0, 1'b0},
        {15'h2AAA, 8'h55, 1'b1, 1'b0, 1'b0},
        {15'h5555, 8'hAA, 1'b1, 1'b0, 1'b0},
        {15'h1000, 8'h77, 1'b0, 1'b1, 1'b1},
        {15'h5555, 8'hAA, 1'b1, 1'b0, 1'b0},
        {15'h2AAA, 8'h55, 1'b1, 1'b0, 1'b0},
        {15'h5555, 8'h80, 1'b1, 1'b0, 1'b0},
        {15'h5555, 8'hAA, 1'b1, 1'b0, 1'b0},
        {15'h2AAA, 8'h55, 1'b1, 1'b0, 1'b0},
        {15'h5555, 8'h20, 1'b1, 1'b0, 1'b0},
        {15'h5555, 8'hAA, 1'b0, 1'b1, 1'b1},
        {15'h5555, 8'hAA, 1'b1, 1'b0, 1'b0},
        {15'h2AAA, 8'h55, 1'b1, 1'b0, 1'b0},
        {15'h5555, 8'hA0, 1'b1, 1'b0, 1'b0},
        {15'h0040, 8'h3C, 1'b0, 1'b0, 1'b0},
        {15'h5555, 8'hAA, 1'b0, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic do_write(input logic [14:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_stb  = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    // Called at the negedge after the edge that sampled the last write
    task automatic wait_close(input string req, input logic exp_commit);
        logic early = 1'b0;
        for (int i = 1; i < 8; i++) begin
            @(negedge clk);
            if (timer_start) early = 1'b1;
        end
        chk({req, " R1 no early start"}, 32'(early), 32'd0);
        @(negedge clk);
        chk({req, " R1 start"}, 32'(timer_start), 32'd1);
        chk({req, " R2 commit"}, 32'(commit_ok), 32'(exp_commit));
    endtask

    task automatic done_pulse();
        cycle_done = 1'b1;
        @(negedge clk);
        cycle_done = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        // R10: power-up and reset state
        repeat (3) @(negedge clk);
        chk("R10 power-up prot", 32'(prot_on), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 reset start", 32'(timer_start), 32'd0);
        chk("R10 reset commit", 32'(commit_ok), 32'd0);
        chk("R10 reset suppress", 32'(cmd_suppress), 32'd0);

        // R5 R6 R7: table of loads while unprotected; last load locks (R3)
        for (int i = 0; i < NV; i++) begin
            do_write(VEC[i][25:11], VEC[i][10:3]);
            chk($sformatf("R5 R6 R7 vector %0d suppress", i), 32'(cmd_suppress), 32'(VEC[i][2]));
            if (VEC[i][1]) begin
                wait_close($sformatf("vector %0d", i), VEC[i][0]);
                chk("R3 R4 prot before done", 32'(prot_on), 32'd0);
                done_pulse();
            end
        end
        chk("R3 lock applied at done", 32'(prot_on), 32'd1);

        // R2: protected plain write, timer still runs, no commit
        do_write(15'h0100, 8'h55);
        chk("R5 plain suppress", 32'(cmd_suppress), 32'd0);
        wait_close("protected plain", 1'b0);
        done_pulse();
        chk("R11 prot kept", 32'(prot_on), 32'd1);

        // R2 R7: prefixed page commits, protection stays
        do_write(15'h5555, 8'hAA);
        do_write(15'h2AAA, 8'h55);
        do_write(15'h5555, 8'hA0);
        chk("R5 prefix suppress", 32'(cmd_suppress), 32'd1);
        do_write(15'h0200, 8'h11);
        chk("R7 data after prefix", 32'(cmd_suppress), 32'd0);
        do_write(15'h0201, 8'h22);
        wait_close("prefixed page", 1'b1);

        // R9: write while busy ignored
        do_write(15'h5555, 8'hAA);
        chk("R9 busy write suppress", 32'(cmd_suppress), 32'd0);
        begin
            logic seen = 1'b0;
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                if (timer_start) seen = 1'b1;
            end
            chk("R9 busy write no start", 32'(seen), 32'd0);
        end
        done_pulse();
        chk("R3 prot kept after prefixed page", 32'(prot_on), 32'd1);
        // R9: stray cycle_done while idle
        done_pulse();
        chk("R9 stray done", 32'(prot_on), 32'd1);

        // R8: pattern split across loads
        do_write(15'h5555, 8'hAA);
        do_write(15'h2AAA, 8'h55);
        wait_close("split first", 1'b0);
        done_pulse();
        do_write(15'h5555, 8'hA0);
        chk("R8 split opcode suppress", 32'(cmd_suppress), 32'd0);
        do_write(15'h0300, 8'h33);
        wait_close("R8 split second", 1'b0);
        done_pulse();

        // R10: reset mid-pattern keeps protection, drops pattern
        do_write(15'h5555, 8'hAA);
        do_write(15'h2AAA, 8'h55);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R10 prot survives reset", 32'(prot_on), 32'd1);
        chk("R10 reset drops suppress", 32'(cmd_suppress), 32'd0);
        do_write(15'h5555, 8'hA0);
        chk("R10 pattern cleared", 32'(cmd_suppress), 32'd0);
        wait_close("R10 after reset", 1'b0);
        done_pulse();

        // R4: unlock while protected
        do_write(15'h5555, 8'hAA);
        do_write(15'h2AAA, 8'h55);
        do_write(15'h5555, 8'h80);
        do_write(15'h5555, 8'hAA);
        do_write(15'h2AAA, 8'h55);
        do_write(15'h5555, 8'h20);
        chk("R4 unlock suppress", 32'(cmd_suppress), 32'd1);
        wait_close("unlock load", 1'b0);
        chk("R4 prot before done", 32'(prot_on), 32'd1);
        done_pulse();
        chk("R4 unlock applied", 32'(prot_on), 32'd0);
        do_write(15'h0400, 8'h44);
        wait_close("R4 open again", 1'b1);
        done_pulse();

        summary();
    end

endmodule